// File: doc/BRIEF.md
# Per-Tap Sign-Agreement Step-Size Adapter

This block holds a separate adaptation step size for every tap of an N-tap adaptive transversal filter. The filter's sequencer visits the taps one at a time. For each visit it presents the current error sample, the input sample delayed by the tap's index, the tap index and an update strobe. The block forms the gradient term for that tap as the signed product of error and delayed input. It compares the gradient's sign with the sign it kept from that tap's previous visit, moves the tap's step size up or down by a fixed increment, and clamps the result to a configured window.

The updated step size comes out one clock after the strobe, together with the tap index it belongs to, so the filter datapath can use it to scale that tap's weight correction. A parameter selects the adaptation rule. The default rule uses only the agreement of signs and suits a compact datapath. The alternative rule adds the product of the current and previous gradient terms, scaled down by an arithmetic right shift; it needs a full-width gradient stored per tap. Filtering, error formation and the weight update itself lie outside this block.

Top module: `tap_stepsize_adapter`

## Requirements
- R1: Each clock edge that samples `upd_i` high makes `valid_o` high for exactly the following cycle, with `tap_o` equal to the sampled `tap_i`. `valid_o` is low after any edge that samples `upd_i` low.
- R2: The gradient term for a visit is the signed product `err_i * xdly_i`, with both operands taken as two's complement. Its sign is positive, negative or zero.
- R3: In sign mode (`MODE`=0), when the current gradient sign equals the stored sign for that tap and both are nonzero, the step size rises by `INC`.
- R4: In sign mode, when the current and stored signs are both nonzero and differ, the step size falls by `INC`.
- R5: When the current gradient is zero, or the stored sign for that tap is zero, the step size is reproduced unchanged.
- R6: Every updated step size is clamped to the closed range [`MU_MIN`, `MU_MAX`].
- R7: Reset loads `MU_INIT` into every tap's step size and clears every stored sign to zero, so the first visit of any tap after reset returns `MU_INIT`. `valid_o` is low during reset.
- R8: A visit changes only the state of the tap it names. Other taps keep their step size and their history.
- R9: Every visit replaces the tap's stored history with the current gradient, including a zero gradient, so a zero gradient erases the previous sign.
- R10: In product mode (`MODE`=1) the step-size change is (g(n) * g(n-1)) arithmetically shifted right by `PSHIFT`, where g(n-1) is the tap's stored previous gradient (zero after reset). The result is then clamped as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_i | input | 1 | Update strobe for the tap named by `tap_i` |
| tap_i | input | $clog2(NTAPS) | Index of the tap being visited |
| err_i | input | DW | Current error sample, signed |
| xdly_i | input | DW | Input sample delayed by `tap_i` samples, signed |
| valid_o | output | 1 | High one cycle after a strobe |
| tap_o | output | $clog2(NTAPS) | Tap index of the step size on `mu_o` |
| mu_o | output | SW | Updated step size of tap `tap_o`, unsigned |

## Verification
The bench aims at the sign-history corner cases:
- The first visit after reset: a design that did not clear the history would step away from `MU_INIT`.
- A zero gradient followed by a nonzero one: a design that skipped writing the zero sign would still step on the next visit.
- Long runs of agreeing and alternating signs, which drive the value into both clamp limits: a missing or off-by-one clamp would leave the window or wrap.
- Interleaved visits to different taps: shared or mis-indexed state would bleed from one tap to another.
- Product mode with negative products: a logical instead of an arithmetic shift would turn a small decrease into a huge increase.
- Back-to-back strobes on the same tap: these expose any read of stale state.

// File: rtl/tsa_pkg.sv
package tsa_pkg;

   localparam int STEP_SIGN    = 0;
   localparam int STEP_PRODUCT = 1;

   typedef enum logic [1:0] {
      SGN_ZERO = 2'b00,
      SGN_POS  = 2'b01,
      SGN_NEG  = 2'b11
   } sgn_e;

   // +1 when both signs are nonzero and equal, -1 when nonzero and opposite, else 0
   function automatic logic signed [1:0] sgn_agree(sgn_e a, sgn_e b);
      if (a == SGN_ZERO || b == SGN_ZERO) return 2'sd0;
      return (a == b) ? 2'sd1 : -2'sd1;
   endfunction

endpackage

// File: rtl/tsa_grad.sv
module tsa_grad #(
   parameter int DW = 12,
   parameter int GW = 2 * DW
) (
   input  logic signed [DW-1:0] err_i,
   input  logic signed [DW-1:0] xdly_i,
   output logic signed [GW-1:0] grad_o,
   output tsa_pkg::sgn_e        sgn_o
);
   import tsa_pkg::*;

   always_comb begin
      grad_o = err_i * xdly_i;
      if (grad_o == '0)        sgn_o = SGN_ZERO;
      else if (grad_o[GW-1])   sgn_o = SGN_NEG;
      else                     sgn_o = SGN_POS;
   end

endmodule

// File: rtl/tsa_store.sv
module tsa_store #(
   parameter int NTAPS   = 8,
   parameter int SW      = 16,
   parameter int GW      = 24,
   parameter int MODE    = 0,
   parameter int MU_INIT = 4096,
   parameter int IW      = $clog2(NTAPS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [IW-1:0]        idx_i,
   input  logic [SW-1:0]        mu_wr,
   input  tsa_pkg::sgn_e        sgn_wr,
   input  logic signed [GW-1:0] grad_wr,
   output logic [SW-1:0]        mu_rd,
   output tsa_pkg::sgn_e        sgn_rd,
   output logic signed [GW-1:0] grad_rd
);
   import tsa_pkg::*;

   logic [SW-1:0] mu_q  [NTAPS];
   sgn_e          sgn_q [NTAPS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NTAPS; i++) begin
            mu_q[i]  <= SW'(MU_INIT);
            sgn_q[i] <= SGN_ZERO;
         end
      end else if (wr_en) begin
         mu_q[idx_i]  <= mu_wr;
         sgn_q[idx_i] <= sgn_wr;
      end
   end

   assign mu_rd  = mu_q[idx_i];
   assign sgn_rd = sgn_q[idx_i];

   generate
      if (MODE == STEP_PRODUCT) begin : g_keep_grad
         logic signed [GW-1:0] grad_q [NTAPS];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < NTAPS; i++) grad_q[i] <= '0;
            end else if (wr_en) begin
               grad_q[idx_i] <= grad_wr;
            end
         end
         assign grad_rd = grad_q[idx_i];
      end else begin : g_sign_only
         logic unused_grad;
         assign unused_grad = ^grad_wr;
         assign grad_rd     = '0;
      end
   endgenerate

endmodule

// File: rtl/tsa_step.sv
module tsa_step #(
   parameter int SW     = 16,
   parameter int GW     = 24,
   parameter int MODE   = 0,
   parameter int INC    = 64,
   parameter int PSHIFT = 10,
   parameter int MU_MIN = 256,
   parameter int MU_MAX = 16384
) (
   input  logic [SW-1:0]        mu_cur,
   input  tsa_pkg::sgn_e        sgn_cur,
   input  tsa_pkg::sgn_e        sgn_prev,
   input  logic signed [GW-1:0] grad_cur,
   input  logic signed [GW-1:0] grad_prev,
   output logic [SW-1:0]        mu_nxt
);
   import tsa_pkg::*;

   localparam int PW   = 2 * GW;
   localparam int SUMW = PW + 2;
   localparam logic signed [SUMW-1:0] LO   = SUMW'(MU_MIN);
   localparam logic signed [SUMW-1:0] HI   = SUMW'(MU_MAX);
   localparam logic signed [SUMW-1:0] INCV = SUMW'(INC);

   logic signed [SUMW-1:0] delta;
   logic signed [SUMW-1:0] total;

   generate
      if (MODE == STEP_PRODUCT) begin : g_product
         logic signed [PW-1:0] prod;
         logic signed [PW-1:0] scaled;
         logic                 unused_sgn;
         assign prod       = grad_cur * grad_prev;
         assign scaled     = prod >>> PSHIFT;
         assign delta      = {{(SUMW-PW){scaled[PW-1]}}, scaled};
         assign unused_sgn = ^{sgn_cur, sgn_prev};
      end else begin : g_sign
         logic signed [1:0] agree;
         logic              unused_grad;
         assign agree       = sgn_agree(sgn_cur, sgn_prev);
         assign delta       = (agree == 2'sd1)  ? INCV :
                              (agree == -2'sd1) ? -INCV : '0;
         assign unused_grad = ^{grad_cur, grad_prev};
      end
   endgenerate

   always_comb begin
      total = $signed({{(SUMW-SW){1'b0}}, mu_cur}) + delta;
      if (total < LO)      mu_nxt = SW'(MU_MIN);
      else if (total > HI) mu_nxt = SW'(MU_MAX);
      else                 mu_nxt = total[SW-1:0];
   end

endmodule

// File: rtl/tap_stepsize_adapter.sv
module tap_stepsize_adapter #(
   parameter int NTAPS   = 8,
   parameter int DW      = 12,
   parameter int SW      = 16,
   parameter int MODE    = 0,
   parameter int INC     = 64,
   parameter int PSHIFT  = 10,
   parameter int MU_MIN  = 256,
   parameter int MU_MAX  = 16384,
   parameter int MU_INIT = 4096
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          upd_i,
   input  logic [$clog2(NTAPS)-1:0]      tap_i,
   input  logic signed [DW-1:0]          err_i,
   input  logic signed [DW-1:0]          xdly_i,
   output logic                          valid_o,
   output logic [$clog2(NTAPS)-1:0]      tap_o,
   output logic [SW-1:0]                 mu_o
);
   import tsa_pkg::*;

   localparam int IW = $clog2(NTAPS);
   localparam int GW = 2 * DW;

   generate
      if (NTAPS < 2 || (NTAPS & (NTAPS - 1)) != 0) begin : g_bad_ntaps
         $error("NTAPS must be a power of two, at least 2");
      end
      if (MODE != STEP_SIGN && MODE != STEP_PRODUCT) begin : g_bad_mode
         $error("MODE must select sign or product adaptation");
      end
      if (MU_MIN > MU_INIT || MU_INIT > MU_MAX || (MU_MAX >> SW) != 0) begin : g_bad_bounds
         $error("step-size bounds must satisfy MIN <= INIT <= MAX < 2**SW");
      end
      if (INC <= 0 || PSHIFT < 0) begin : g_bad_inc
         $error("INC must be positive and PSHIFT non-negative");
      end
   endgenerate

   logic signed [GW-1:0] grad_cur, grad_prev;
   sgn_e                 sgn_cur, sgn_prev;
   logic [SW-1:0]        mu_cur, mu_nxt;

   tsa_grad #(.DW(DW), .GW(GW)) u_grad (
      .err_i  (err_i),
      .xdly_i (xdly_i),
      .grad_o (grad_cur),
      .sgn_o  (sgn_cur)
   );

   tsa_store #(
      .NTAPS(NTAPS), .SW(SW), .GW(GW), .MODE(MODE), .MU_INIT(MU_INIT), .IW(IW)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (upd_i),
      .idx_i   (tap_i),
      .mu_wr   (mu_nxt),
      .sgn_wr  (sgn_cur),
      .grad_wr (grad_cur),
      .mu_rd   (mu_cur),
      .sgn_rd  (sgn_prev),
      .grad_rd (grad_prev)
   );

   tsa_step #(
      .SW(SW), .GW(GW), .MODE(MODE), .INC(INC), .PSHIFT(PSHIFT),
      .MU_MIN(MU_MIN), .MU_MAX(MU_MAX)
   ) u_step (
      .mu_cur    (mu_cur),
      .sgn_cur   (sgn_cur),
      .sgn_prev  (sgn_prev),
      .grad_cur  (grad_cur),
      .grad_prev (grad_prev),
      .mu_nxt    (mu_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         tap_o   <= '0;
         mu_o    <= '0;
      end else begin
         valid_o <= upd_i;
         if (upd_i) begin
            tap_o <= tap_i;
            mu_o  <= mu_nxt;
         end
      end
   end

endmodule

// File: rtl/tsa_chk.sv
module tsa_chk #(
   parameter int NTAPS   = 8,
   parameter int DW      = 12,
   parameter int SW      = 16,
   parameter int MODE    = 0,
   parameter int INC     = 64,
   parameter int MU_MIN  = 256,
   parameter int MU_MAX  = 16384,
   parameter int MU_INIT = 4096
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     upd_i,
   input logic [$clog2(NTAPS)-1:0] tap_i,
   input logic signed [DW-1:0]     err_i,
   input logic signed [DW-1:0]     xdly_i,
   input logic                     valid_o,
   input logic [$clog2(NTAPS)-1:0] tap_o,
   input logic [SW-1:0]            mu_o
);

   // last step size seen on the outputs for each tap, seeded with the reset value
   logic [SW-1:0] seen_mu [NTAPS];
   logic [SW-1:0] prior, diff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NTAPS; i++) seen_mu[i] <= SW'(MU_INIT);
      end else if (valid_o) begin
         seen_mu[tap_o] <= mu_o;
      end
   end

   assign prior = seen_mu[tap_o];
   assign diff  = (mu_o >= prior) ? (mu_o - prior) : (prior - mu_o);

   AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      upd_i |=> valid_o); // R1
   AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_i |=> !valid_o); // R1
   AST_TAP_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
      upd_i |=> (tap_o == $past(tap_i))); // R1
   AST_MU_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (mu_o >= SW'(MU_MIN) && mu_o <= SW'(MU_MAX))); // R6
   AST_ZERO_GRAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_i && (err_i == '0 || xdly_i == '0)) |=> (mu_o == prior)); // R5

   generate
      if (MODE == 0) begin : g_sign_chk
         AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
            valid_o |-> (diff <= SW'(INC))); // R3
      end
   endgenerate

endmodule

bind tap_stepsize_adapter tsa_chk #(
   .NTAPS(NTAPS), .DW(DW), .SW(SW), .MODE(MODE), .INC(INC),
   .MU_MIN(MU_MIN), .MU_MAX(MU_MAX), .MU_INIT(MU_INIT)
) u_tsa_chk (.*);

// File: tb/tap_stepsize_adapter_bench.sv
`timescale 1ns/1ps
module tap_stepsize_adapter_bench;

   localparam int NT   = 4;
   localparam int DW   = 8;
   localparam int SW   = 12;
   localparam int INC  = 16;
   localparam int PS   = 6;
   localparam int MIN  = 32;
   localparam int MAX  = 256;
   localparam int INIT = 128;
   localparam int IW   = $clog2(NT);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic upd = 1'b0;
   logic [IW-1:0] tap = '0;
   logic signed [DW-1:0] err = '0, xd = '0;
   logic vs, vp;
   logic [IW-1:0] ts, tp;
   logic [SW-1:0] ms, mp;

   always #4 clk = ~clk;

   tap_stepsize_adapter #(.NTAPS(NT), .DW(DW), .SW(SW), .MODE(0), .INC(INC),
      .PSHIFT(PS), .MU_MIN(MIN), .MU_MAX(MAX), .MU_INIT(INIT)) u_tap_stepsize_adapter (
      .clk(clk), .rst_n(rst_n), .upd_i(upd), .tap_i(tap), .err_i(err), .xdly_i(xd),
      .valid_o(vs), .tap_o(ts), .mu_o(ms));

   tap_stepsize_adapter #(.NTAPS(NT), .DW(DW), .SW(SW), .MODE(1), .INC(INC),
      .PSHIFT(PS), .MU_MIN(MIN), .MU_MAX(MAX), .MU_INIT(INIT)) u_tap_stepsize_adapter_prod (
      .clk(clk), .rst_n(rst_n), .upd_i(upd), .tap_i(tap), .err_i(err), .xdly_i(xd),
      .valid_o(vp), .tap_o(tp), .mu_o(mp));

   typedef struct {
      int    tap;
      int    mu_s;
      int    mu_p;
      string req;
   } exp_t;

   exp_t q[$];
   int   nvec = 0, nbad = 0;
   bit   idle_chk = 1'b0;
   bit   done = 1'b0;

   // bench model state
   int m_mu_s [NT];
   int m_sg   [NT];
   int m_mu_p [NT];
   longint m_g [NT];

   function automatic int sgn(longint v);
      return (v > 0) ? 1 : (v < 0) ? -1 : 0;
   endfunction

   function automatic int clampv(longint v);
      if (v < MIN) return MIN;
      if (v > MAX) return MAX;
      return int'(v);
   endfunction

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
   endtask

   task automatic apply(int t, int e, int x, string req);
      longint g;
      exp_t it;
      @(negedge clk);
      upd = 1'b1; tap = IW'(t); err = DW'(e); xd = DW'(x);
      g = longint'(e) * longint'(x);
      m_mu_s[t] = clampv(longint'(m_mu_s[t]) + longint'(sgn(g) * m_sg[t] * INC));
      m_sg[t]   = sgn(g);
      m_mu_p[t] = clampv(longint'(m_mu_p[t]) + ((g * m_g[t]) >>> PS));
      m_g[t]    = g;
      it.tap = t; it.mu_s = m_mu_s[t]; it.mu_p = m_mu_p[t]; it.req = req;
      q.push_back(it);
   endtask

   task automatic idle(int n);
      @(negedge clk);
      upd = 1'b0;
      repeat (n - 1) @(negedge clk);
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (vs || vp) begin
            nvec++;
            if (q.size() == 0) begin
               nbad++;
               $display("FAIL R1: valid without strobe, got valid=%0b/%0b expected 0/0", vs, vp);
            end else begin
               exp_t it;
               it = q.pop_front();
               if (!(vs && vp) || ts != IW'(it.tap) || tp != IW'(it.tap)) begin
                  nbad++;
                  $display("FAIL R1 (%s): valid=%0b/%0b tap=%0d/%0d expected valid 1/1 tap %0d",
                           it.req, vs, vp, ts, tp, it.tap);
               end
               if (int'(ms) != it.mu_s) begin
                  nbad++;
                  $display("FAIL %s sign mode: mu=%0d expected %0d", it.req, ms, it.mu_s);
               end
               if (int'(mp) != it.mu_p) begin
                  nbad++;
                  $display("FAIL %s product mode R10: mu=%0d expected %0d", it.req, mp, it.mu_p);
               end
            end
         end else if (idle_chk) begin
            nvec++; // R1: no strobe, no valid
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      nbad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < NT; i++) begin
         m_mu_s[i] = INIT; m_sg[i] = 0; m_mu_p[i] = INIT; m_g[i] = 0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      nvec++;
      if (vs || vp) begin // R7: outputs idle in reset
         nbad++;
         $display("FAIL R7: valid during reset got %0b/%0b expected 0/0", vs, vp);
      end
      rst_n = 1'b1;

      apply(0, 3, 5, "R7");      // first visit after reset keeps initial value
      apply(0, 2, 4, "R3");      // same sign: up
      apply(0, -2, 4, "R4");     // opposite: down, negative product shifts arithmetically
      apply(0, -3, -3, "R2");    // neg*neg is positive: agrees with nothing stored negative
      apply(0, 0, 9, "R5");      // zero gradient: unchanged
      apply(0, 5, 5, "R9");      // stored sign was cleared by zero: unchanged
      apply(0, 5, 5, "R3");
      apply(1, 7, -7, "R8");     // untouched tap still at initial value
      for (int i = 0; i < 12; i++) apply(2, 4, 3, "R6");           // drive to upper limit
      for (int i = 0; i < 12; i++) apply(3, (i % 2) ? -3 : 3, 3, "R6"); // drive to lower limit
      apply(0, 1, 1, "R8");      // tap 0 history intact after other taps ran
      apply(1, 100, 100, "R10"); // large product
      apply(1, -100, 100, "R10");// large negative product clamps low
      apply(1, -100, -100, "R10");
      apply(2, 9, 0, "R5");
      idle(1);
      idle_chk = 1'b1;
      idle(6);
      idle_chk = 1'b0;
      apply(3, 6, 6, "R3");
      idle(4);

      nvec++;
      if (q.size() != 0) begin
         nbad++;
         $display("FAIL R1: %0d results never appeared, expected 0 pending", q.size());
      end
      done = 1'b1;
      summary();
      $finish;
   end

endmodule